// File: doc/BRIEF.md
# Addressed Serial Configuration Master

This block turns one host request into one framed serial transfer on a shared four-wire serial bus that carries many configuration slaves. The host gives a 7-bit slave address, a frame length of 1 to 64 bits, the outgoing data and a readback flag, then pulses start. The block decodes the address into one active-low select out of 128 and clocks the frame out most significant bit first in SPI mode 0. At the end it pulses done for one cycle.

The bus also has a fifth line that asks a slave to present the contents it has already stored. For a readback request the block raises that line for one full serial clock period, with every select inactive, before the frame starts. It then gathers the bits returned on the input data line into the read-data register. A separate override reset output follows a host input with no clocked path. The host can therefore force every slave into its initial state at any moment, whether or not a transfer is running. Frame length and target are chosen per transfer, so converter parts with short frames and custom chips with long configuration words can share the bus.

Top module: `cfg_spi_master`

## Requirements
- R1: After reset all 128 selects are high, the serial clock, the load line, busy and done are low, and the read-data register is zero.
- R2: The serial clock idles low and each of its high and low phases lasts exactly HALF_DIV system clocks. The default of 25 at a 250 MHz system clock gives 5 MHz.
- R3: During a transfer, the select whose index equals the 7-bit address is low and every other select stays high.
- R4: The frame length field holds the bit count minus one, from 0 to 63. Exactly that many plus one rising serial clock edges occur, and the slave sees the low-order bits of the write data, most significant first, stable at each rising edge.
- R5: The select falls HALF_DIV system clocks before the first rising edge and rises HALF_DIV system clocks after the last falling edge.
- R6: For readback (read flag 1), the load line is high for 2*HALF_DIV system clocks while all selects are high, and the select falls on the same clock that load falls. The input data line is sampled at each rising edge, and the read-data register then holds the received bits right-aligned, first bit highest, with all upper bits zero.
- R7: A write transfer (read flag 0) never raises the load line and leaves the read-data register unchanged.
- R8: Busy is high from the clock after an accepted start until the transfer ends. Done is high for exactly one clock, on the clock where busy falls.
- R9: A start pulse that arrives while busy is high is ignored. The running transfer keeps its address and data, and no second transfer follows.
- R10: The override reset output is low exactly while the override input is high, with no clock involved, and asserting it does not disturb a running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset of the block |
| startIn | input | 1 | Request a transfer; taken only when idle |
| readIn | input | 1 | 1 = readback transfer with load phase, 0 = write |
| addrIn | input | ADDR_W (7) | Slave address, picks one select |
| lenM1In | input | LEN_W (6) | Frame length minus one |
| wrDataIn | input | MAX_BITS (64) | Outgoing frame, right-aligned |
| ovrRstIn | input | 1 | Host request for the override reset |
| rdDataOut | output | MAX_BITS (64) | Bits returned by the last readback, right-aligned |
| busyOut | output | 1 | Transfer in progress |
| doneOut | output | 1 | One-clock pulse at the end of a transfer |
| spiSckOut | output | 1 | Serial clock, idle low |
| spiMosiOut | output | 1 | Serial data toward the slaves |
| spiMisoIn | input | 1 | Serial data from the selected slave |
| spiLoadOut | output | 1 | Readback request line |
| spiRstNOut | output | 1 | Active-low override reset toward the slaves |
| spiSelNOut | output | NUM_SEL (128) | Active-low slave selects |

## Verification
Transfers go to the lowest and highest addresses and to one address in between. This separates a correct decode from one that is stuck or shifted by a bit. Frame lengths of one bit, 64 bits and an odd middle value test the end-of-frame count and the left alignment of the outgoing data. Readbacks return patterns that differ from the written data, so a capture on the wrong edge or a capture with the wrong alignment shows up as a wrong value. A start pulse issued partway through a transfer, and an override pulse during a transfer, show that neither of them changes what the slave receives.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } ctrlState_e;

  // strobes from the sequencer to the datapath, one clock wide each
  typedef struct packed {
    logic loadFrame;   // capture request fields
    logic shiftOut;    // advance outgoing bit after a falling edge
    logic sampleIn;    // take the input bit at a rising edge
    logic commitRead;  // copy received bits to the read register
  } dpStrobe_t;

endpackage

// File: rtl/cfg_spi_ctrl.sv
module cfg_spi_ctrl
  import cfg_spi_pkg::*;
#(
  parameter int HALF_DIV = 25,
  parameter int LEN_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             readIn,
  input  logic [LEN_W-1:0] lenM1In,
  output dpStrobe_t        stb,
  output logic             sckOut,
  output logic             selActiveOut,
  output logic             loadOut,
  output logic             busyOut,
  output logic             doneOut
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  ctrlState_e       state;
  logic [DIV_W-1:0] divCnt;
  logic [LEN_W-1:0] bitCnt;
  logic             readLat;
  logic             loadHalf;
  logic             tick;

  assign tick    = (divCnt == DIV_LAST);
  assign busyOut = (state != ST_IDLE);

  always_comb begin
    stb            = '0;
    stb.loadFrame  = (state == ST_IDLE) && startIn;
    stb.sampleIn   = tick && ((state == ST_SETUP) || ((state == ST_SHIFT) && !sckOut));
    stb.shiftOut   = tick && (state == ST_SHIFT) && sckOut && (bitCnt != '0);
    stb.commitRead = tick && (state == ST_HOLD) && readLat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      divCnt       <= '0;
      bitCnt       <= '0;
      readLat      <= 1'b0;
      loadHalf     <= 1'b0;
      sckOut       <= 1'b0;
      selActiveOut <= 1'b0;
      loadOut      <= 1'b0;
      doneOut      <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      if (state == ST_IDLE) begin
        if (startIn) begin
          readLat  <= readIn;
          bitCnt   <= lenM1In;
          divCnt   <= '0;
          loadHalf <= 1'b0;
          if (readIn) begin
            state   <= ST_LOAD;
            loadOut <= 1'b1;
          end else begin
            state        <= ST_SETUP;
            selActiveOut <= 1'b1;
          end
        end
      end else if (!tick) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt <= '0;
        unique case (state)
          ST_LOAD: begin
            loadHalf <= 1'b1;
            if (loadHalf) begin
              loadOut      <= 1'b0;
              selActiveOut <= 1'b1;
              state        <= ST_SETUP;
            end
          end
          ST_SETUP: begin
            sckOut <= 1'b1;
            state  <= ST_SHIFT;
          end
          ST_SHIFT: begin
            sckOut <= !sckOut;
            if (sckOut) begin
              if (bitCnt == '0) state <= ST_HOLD;
              else              bitCnt <= bitCnt - 1'b1;
            end
          end
          ST_HOLD: begin
            selActiveOut <= 1'b0;
            doneOut      <= 1'b1;
            state        <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_spi_dp.sv
module cfg_spi_dp
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int MAX_BITS = 64,
  parameter int LEN_W    = 6,
  parameter int NUM_SEL  = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [LEN_W-1:0]    lenM1In,
  input  logic [MAX_BITS-1:0] wrDataIn,
  input  logic                misoIn,
  input  logic                selActiveIn,
  output logic                mosiOut,
  output logic [NUM_SEL-1:0]  selNOut,
  output logic [MAX_BITS-1:0] rdDataOut
);

  localparam logic [LEN_W-1:0] TOP_POS = LEN_W'(MAX_BITS - 1);

  logic [ADDR_W-1:0]   addrLat;
  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;

  assign mosiOut = txShift[MAX_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLat   <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      rdDataOut <= '0;
    end else begin
      if (stb.loadFrame) begin
        addrLat <= addrIn;
        // left-align so the first bit to send sits at the top
        txShift <= wrDataIn << (TOP_POS - lenM1In);
        rxShift <= '0;
      end
      if (stb.shiftOut)   txShift   <= {txShift[MAX_BITS-2:0], 1'b0};
      if (stb.sampleIn)   rxShift   <= {rxShift[MAX_BITS-2:0], misoIn};
      if (stb.commitRead) rdDataOut <= rxShift;
    end
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign selNOut[g] = !(selActiveIn && (addrLat == ADDR_W'(g)));
  end

endmodule

// File: rtl/cfg_spi_master.sv
module cfg_spi_master
  import cfg_spi_pkg::*;
#(
  parameter int HALF_DIV = 25,
  parameter int ADDR_W   = 7,
  parameter int MAX_BITS = 64,
  parameter int LEN_W    = $clog2(MAX_BITS),
  parameter int NUM_SEL  = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                readIn,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [LEN_W-1:0]    lenM1In,
  input  logic [MAX_BITS-1:0] wrDataIn,
  input  logic                ovrRstIn,
  output logic [MAX_BITS-1:0] rdDataOut,
  output logic                busyOut,
  output logic                doneOut,
  output logic                spiSckOut,
  output logic                spiMosiOut,
  input  logic                spiMisoIn,
  output logic                spiLoadOut,
  output logic                spiRstNOut,
  output logic [NUM_SEL-1:0]  spiSelNOut
);

  dpStrobe_t stb;
  logic      selActive;

  // override reset has no clocked path
  assign spiRstNOut = !ovrRstIn;

  cfg_spi_ctrl #(
    .HALF_DIV(HALF_DIV),
    .LEN_W   (LEN_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startIn     (startIn),
    .readIn      (readIn),
    .lenM1In     (lenM1In),
    .stb         (stb),
    .sckOut      (spiSckOut),
    .selActiveOut(selActive),
    .loadOut     (spiLoadOut),
    .busyOut     (busyOut),
    .doneOut     (doneOut)
  );

  cfg_spi_dp #(
    .ADDR_W  (ADDR_W),
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W),
    .NUM_SEL (NUM_SEL)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addrIn     (addrIn),
    .lenM1In    (lenM1In),
    .wrDataIn   (wrDataIn),
    .misoIn     (spiMisoIn),
    .selActiveIn(selActive),
    .mosiOut    (spiMosiOut),
    .selNOut    (spiSelNOut),
    .rdDataOut  (rdDataOut)
  );

endmodule

// File: rtl/cfg_spi_checker.sv
module cfg_spi_checker #(
  parameter int NUM_SEL = 128
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               sck,
  input logic               load,
  input logic [NUM_SEL-1:0] selN
);

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~selN));

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  a_r5_sck_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !(&selN));

  a_r6_load_without_select: assert property (@(posedge clk) disable iff (!rstN)
    load |-> (&selN));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind cfg_spi_master cfg_spi_checker #(.NUM_SEL(NUM_SEL)) chk_i (
  .clk (clk),
  .rstN(rstN),
  .busy(busyOut),
  .done(doneOut),
  .sck (spiSckOut),
  .load(spiLoadOut),
  .selN(spiSelNOut)
);

// File: tb/cfg_spi_master_tb_top.sv
module cfg_spi_master_tb_top;

  localparam int HALF = 25;
  localparam int AW   = 7;
  localparam int MB   = 64;
  localparam int LW   = 6;
  localparam int NS   = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic          readIn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [LW-1:0] lenM1In = '0;
  logic [MB-1:0] wrDataIn = '0;
  logic          ovrRstIn = 1'b0;
  logic [MB-1:0] rdDataOut;
  logic          busyOut, doneOut, spiSckOut, spiMosiOut, spiLoadOut, spiRstNOut;
  logic          spiMisoIn = 1'b0;
  logic [NS-1:0] spiSelNOut;

  always #2 clk = ~clk;  // 250 MHz

  cfg_spi_master dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .readIn(readIn),
    .addrIn(addrIn), .lenM1In(lenM1In), .wrDataIn(wrDataIn),
    .ovrRstIn(ovrRstIn), .rdDataOut(rdDataOut), .busyOut(busyOut),
    .doneOut(doneOut), .spiSckOut(spiSckOut), .spiMosiOut(spiMosiOut),
    .spiMisoIn(spiMisoIn), .spiLoadOut(spiLoadOut), .spiRstNOut(spiRstNOut),
    .spiSelNOut(spiSelNOut)
  );

  int nCmp = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bus monitor / slave model ----------------
  logic        monClr = 1'b0;
  logic [63:0] reply = '0;
  int          replyLen = 1;
  int          cyc = 0, selFalls = 0, selIdx = -1, multiSel = 0;
  int          selFallCyc = 0, selRiseCyc = 0, firstRise = -1, lastFall = 0;
  int          lastEdge = -1, halfMin = 1000000, halfMax = 0, riseCnt = 0;
  int          loadRise = -1, loadFall = -1, loadOverlap = 0, doneCnt = 0;
  int          bitIdx = 0;
  logic [63:0] rxBits = '0;
  logic        prevSck = 1'b0, prevLoad = 1'b0, prevAnySel = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (monClr) begin
      selFalls = 0; selIdx = -1; multiSel = 0; firstRise = -1; lastEdge = -1;
      halfMin = 1000000; halfMax = 0; riseCnt = 0; loadRise = -1; loadFall = -1;
      loadOverlap = 0; doneCnt = 0; rxBits = '0;
    end else begin
      if (doneOut) doneCnt++;
      if ($countones(~spiSelNOut) > 1) multiSel++;
      for (int i = 0; i < NS; i++) if (!spiSelNOut[i]) selIdx = i;
      if (spiLoadOut && !(&spiSelNOut)) loadOverlap++;
      if (spiLoadOut && !prevLoad) loadRise = cyc;
      if (!spiLoadOut && prevLoad) loadFall = cyc;
      if (!(&spiSelNOut) && !prevAnySel) begin
        selFalls++; selFallCyc = cyc; bitIdx = replyLen - 1;
        spiMisoIn = reply[bitIdx];
      end
      if ((&spiSelNOut) && prevAnySel) selRiseCyc = cyc;
      if (spiSckOut != prevSck) begin
        if (lastEdge >= 0) begin
          if (cyc - lastEdge < halfMin) halfMin = cyc - lastEdge;
          if (cyc - lastEdge > halfMax) halfMax = cyc - lastEdge;
        end
        lastEdge = cyc;
        if (spiSckOut) begin
          if (firstRise < 0) firstRise = cyc;
          riseCnt++;
          rxBits = {rxBits[62:0], spiMosiOut};
        end else begin
          lastFall = cyc;
          bitIdx--;
          if (bitIdx >= 0) spiMisoIn = reply[bitIdx];
        end
      end
    end
    prevSck = spiSckOut;
    prevLoad = spiLoadOut;
    prevAnySel = !(&spiSelNOut);
  end

  logic [63:0] expRd = '0;

  function automatic logic [63:0] maskOf(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic clearMon();
    @(posedge clk); monClr = 1'b1;
    @(posedge clk); monClr = 1'b0;
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busyOut && t < 10000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic launch(input int a, input int lm1, input logic [63:0] d,
                        input bit rd);
    @(negedge clk);
    addrIn = AW'(a); lenM1In = LW'(lm1); wrDataIn = d; readIn = rd;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chk(busyOut == 1'b1, "R8 busy after start", 64'(busyOut), 64'd1);
  endtask

  task automatic checkFrame(input int a, input int lm1, input logic [63:0] d,
                            input bit rd, input logic [63:0] rep);
    int n = lm1 + 1;
    chk(selFalls == 1, "R3 one select window", 64'(selFalls), 64'd1);
    chk(selIdx == a && multiSel == 0, "R3 select index", 64'(selIdx), 64'(a));
    chk(riseCnt == n, "R4 rising edge count", 64'(riseCnt), 64'(n));
    chk((rxBits & maskOf(n)) == (d & maskOf(n)), "R4 slave data",
        rxBits & maskOf(n), d & maskOf(n));
    chk(halfMin == HALF && halfMax == HALF, "R2 sck half period",
        64'(halfMax), 64'(HALF));
    chk(firstRise - selFallCyc == HALF, "R5 select setup",
        64'(firstRise - selFallCyc), 64'(HALF));
    chk(selRiseCyc - lastFall == HALF, "R5 select hold",
        64'(selRiseCyc - lastFall), 64'(HALF));
    chk(doneCnt == 1, "R8 single done", 64'(doneCnt), 64'd1);
    if (rd) begin
      expRd = rep & maskOf(n);
      chk(loadFall - loadRise == 2 * HALF, "R6 load width",
          64'(loadFall - loadRise), 64'(2 * HALF));
      chk(loadOverlap == 0 && loadFall == selFallCyc, "R6 load before select",
          64'(loadFall), 64'(selFallCyc));
    end else begin
      chk(loadRise < 0, "R7 no load on write", 64'(loadRise + 1), 64'd0);
    end
    chk(rdDataOut == expRd, rd ? "R6 readback data" : "R7 read data kept",
        rdDataOut, expRd);
  endtask

  task automatic runXfer(input int a, input int lm1, input logic [63:0] d,
                         input bit rd, input logic [63:0] rep);
    reply = rep; replyLen = lm1 + 1;
    clearMon();
    launch(a, lm1, d, rd);
    waitIdle();
    checkFrame(a, lm1, d, rd, rep);
  endtask

  task automatic testReset();
    chk(&spiSelNOut, "R1 selects high", 64'(&spiSelNOut), 64'd1);
    chk({spiSckOut, spiLoadOut, busyOut, doneOut} == 4'b0, "R1 idle outputs",
        64'({spiSckOut, spiLoadOut, busyOut, doneOut}), 64'd0);
    chk(rdDataOut == '0, "R1 read data zero", rdDataOut, 64'd0);
  endtask

  task automatic testBusyIgnored();
    reply = '0; replyLen = 8;
    clearMon();
    launch(10, 7, 64'h5A, 1'b0);
    repeat (100) @(negedge clk);
    addrIn = 7'd99; wrDataIn = 64'hFF; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    waitIdle();
    checkFrame(10, 7, 64'h5A, 1'b0, 64'h0);
    repeat (HALF * 4) @(negedge clk);
    chk(!busyOut && (&spiSelNOut) && selFalls == 1, "R9 start ignored",
        64'(selFalls), 64'd1);
  endtask

  task automatic testOverride();
    reply = 64'h3C; replyLen = 8;
    clearMon();
    launch(77, 7, 64'hC3, 1'b1);
    repeat (200) @(negedge clk);
    ovrRstIn = 1'b1;
    #1;
    chk(spiRstNOut == 1'b0, "R10 override asserted", 64'(spiRstNOut), 64'd0);
    repeat (30) @(negedge clk);
    ovrRstIn = 1'b0;
    #1;
    chk(spiRstNOut == 1'b1, "R10 override released", 64'(spiRstNOut), 64'd1);
    waitIdle();
    checkFrame(77, 7, 64'hC3, 1'b1, 64'h3C);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    chk(spiRstNOut == 1'b1, "R10 idle override", 64'(spiRstNOut), 64'd1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runXfer(0, 0, 64'h1, 1'b0, 64'h0);                          // R4 one bit
    runXfer(127, 63, 64'hA5C3_0F96_1234_FEDC, 1'b0, 64'h0);     // R3 top addr
    runXfer(45, 22, 64'hFFFF_FFFF_FF5A_B3C1, 1'b0, 64'h0);      // R4 masking
    runXfer(3, 15, 64'h0, 1'b1, 64'hBEEF);                      // R6 16 bits
    runXfer(64, 11, 64'hABC, 1'b0, 64'h0);                      // R7 keep rd
    runXfer(1, 63, 64'h0F0F, 1'b1, 64'h8123_4567_89AB_CDEF);    // R6 64 bits
    runXfer(126, 0, 64'h0, 1'b1, 64'h1);                        // R6 one bit
    testBusyIgnored();                                          // R9
    testOverride();                                             // R10
    finishRun();
  end

endmodule